// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Shared DAC

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter that has no converter DAC of its own. It borrows the DAC that normally drives the analog output. While idle, the DAC code simply follows the user output value. A start strobe does three things: it latches the input sample, raises a hold request so the output track-and-hold keeps the old analog level, and takes over the DAC. The block then tries one bit per cycle, from the most significant bit down to the least. For each trial it presents a code and keeps the bit when the comparator reports that the sampled input is at or above that trial level.

When the last trial ends, the result register is loaded and a one-cycle done pulse is raised. The hold request drops and the DAC goes back to the user value. Single-ended results come out as straight binary. Differential results are searched in offset binary, where trial code 0x80 stands for a zero difference. Their most significant bit is then inverted, so the stored value is two's complement and a zero difference reads 0x00.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, result_o is 0x00, done_o, hold_o and sample_o are 0, and dac_code_o equals dac_user_i.
- R2: While no conversion is running, dac_code_o follows dac_user_i combinationally and hold_o is 0.
- R3: A start_i seen high at a clock edge while idle makes sample_o high for exactly the next cycle. hold_o is then high for 9 consecutive cycles: that sample cycle plus 8 trial cycles.
- R4: In trial cycle k (k = 0..7, after the sample cycle), dac_code_o holds the bits already decided above position 7-k, a 1 at position 7-k, and zeros below it. The bit is kept when cmp_i is high during that cycle.
- R5: When diff_i was 0 at start, the result is the straight binary code found by the search, from 0x00 up to 0xFF.
- R6: When diff_i was 1 at start, the search code is offset binary, with 0x80 meaning a zero difference. The stored result is that code with bit 7 inverted: two's complement, where a zero difference gives 0x00, -1 gives 0xFF and -128 gives 0x80.
- R7: done_o is high for exactly one cycle, the cycle after the eighth trial. result_o takes its new value in that same cycle and keeps it until the next done_o.
- R8: start_i while a conversion runs (sample or trial cycles) is ignored. The running conversion neither restarts nor changes, and sample_o stays low.
- R9: diff_i is used only at the accepted start. Changes to it during a conversion do not alter the result.
- R10: In the done cycle, hold_o is 0 and dac_code_o equals dac_user_i again.
- R11: Changes to dac_user_i during a conversion do not alter the trial codes. After the conversion, dac_code_o shows the new dac_user_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request strobe |
| diff_i | input | 1 | Selected channel is differential |
| cmp_i | input | 1 | Comparator: sampled input at or above current DAC level |
| dac_user_i | input | 8 | User output value for the DAC |
| dac_code_o | output | 8 | Code applied to the shared DAC |
| hold_o | output | 1 | Hold request to the output track-and-hold |
| sample_o | output | 1 | Sample strobe for the input track-and-hold |
| result_o | output | 8 | Conversion result register |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
The embedded properties assume two things. First, cmp_i settles within the cycle in which a trial code is shown. Second, a start strobe may come at any time, including during a conversion. The bench models the comparator combinationally from dac_code_o against a level it latches on sample_o, so the first assumption always holds. It also deliberately asserts start_i, flips diff_i and changes dac_user_i in the middle of a conversion, to exercise the inputs the design must ignore.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_TRIAL  = 2'd2
    } sar_state_e;

    typedef struct packed {
        logic accept;    // start taken this cycle
        logic busy;      // sample or trial cycle
        logic sampling;  // sample cycle
        logic trialing;  // one of the trial cycles
        logic last;      // final trial cycle
    } seq_ctl_t;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    output seq_ctl_t     ctl_o,
    output logic [W-1:0] mask_o
);

    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    sar_state_e   state_q;
    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) state_q <= ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    state_q <= ST_TRIAL;
                    mask_q  <= TOP_BIT;
                end
                ST_TRIAL: begin
                    if (mask_q[0]) begin
                        state_q <= ST_IDLE;
                        mask_q  <= '0;
                    end else begin
                        mask_q  <= mask_q >> 1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    mask_q  <= '0;
                end
            endcase
        end
    end

    always_comb begin
        ctl_o.accept   = (state_q == ST_IDLE) && start_i;
        ctl_o.sampling = (state_q == ST_SAMPLE);
        ctl_o.trialing = (state_q == ST_TRIAL);
        ctl_o.busy     = (state_q != ST_IDLE);
        ctl_o.last     = (state_q == ST_TRIAL) && mask_q[0];
    end

    assign mask_o = mask_q;

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start_i) |=> (state_q != ST_SAMPLE));

    // R4
    trial_mask_single_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRIAL) |-> ($countones(mask_q) == 1));

    // R3
    sample_to_trial_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SAMPLE) |=> (state_q == ST_TRIAL && mask_q == TOP_BIT));

endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sampling_i,
    input  logic         trialing_i,
    input  logic [W-1:0] mask_i,
    input  logic         cmp_i,
    output logic [W-1:0] trial_o,
    output logic [W-1:0] final_o
);

    logic [W-1:0] acc_q;
    logic [W-1:0] keep;

    assign trial_o = acc_q | mask_i;
    assign keep    = cmp_i ? trial_o : acc_q;
    assign final_o = keep;

    always_ff @(posedge clk) begin
        if (rst)             acc_q <= '0;
        else if (sampling_i) acc_q <= '0;
        else if (trialing_i) acc_q <= keep;
    end

    // R4
    acc_bits_kept_chk: assert property (@(posedge clk) disable iff (rst)
        trialing_i |=> ((acc_q & $past(acc_q)) == $past(acc_q)));

    // R4
    lower_bits_clear_chk: assert property (@(posedge clk) disable iff (rst)
        trialing_i |-> ((acc_q & (mask_i | (mask_i - 1'b1))) == '0));

endmodule

// File: rtl/sar_dacmux.sv
module sar_dacmux #(
    parameter int W = 8
) (
    input  logic         busy_i,
    input  logic         trialing_i,
    input  logic [W-1:0] trial_i,
    input  logic [W-1:0] user_i,
    output logic [W-1:0] dac_o,
    output logic         hold_o
);

    assign dac_o  = trialing_i ? trial_i : user_i;
    assign hold_o = busy_i;

    // R2
    always_comb begin
        if (!busy_i) begin
            trial_path_idle_chk: assert (!trialing_i);
        end
    end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         diff_i,
    input  logic         cmp_i,
    input  logic [W-1:0] dac_user_i,
    output logic [W-1:0] dac_code_o,
    output logic         hold_o,
    output logic         sample_o,
    output logic [W-1:0] result_o,
    output logic         done_o
);

    localparam logic [W-1:0] SIGN_FLIP = {1'b1, {(W-1){1'b0}}};

    seq_ctl_t     ctl;
    logic [W-1:0] mask;
    logic [W-1:0] trial;
    logic [W-1:0] final_code;
    logic         diff_q;
    logic [W-1:0] result_q;
    logic         done_q;

    sar_seq #(.W(W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ctl_o   (ctl),
        .mask_o  (mask)
    );

    sar_reg #(.W(W)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .sampling_i (ctl.sampling),
        .trialing_i (ctl.trialing),
        .mask_i     (mask),
        .cmp_i      (cmp_i),
        .trial_o    (trial),
        .final_o    (final_code)
    );

    sar_dacmux #(.W(W)) u_mux (
        .busy_i     (ctl.busy),
        .trialing_i (ctl.trialing),
        .trial_i    (trial),
        .user_i     (dac_user_i),
        .dac_o      (dac_code_o),
        .hold_o     (hold_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            diff_q   <= 1'b0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            if (ctl.accept) diff_q <= diff_i;
            if (ctl.last)   result_q <= diff_q ? (final_code ^ SIGN_FLIP) : final_code;
            done_q <= ctl.last;
        end
    end

    assign sample_o = ctl.sampling;
    assign result_o = result_q;
    assign done_o   = done_q;

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R7
    result_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(result_q));

    // R11
    dac_taken_only_held_chk: assert property (@(posedge clk) disable iff (rst)
        (dac_code_o != dac_user_i) |-> hold_o);

    // R10
    done_releases_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !hold_o);

    // R4
    first_trial_msb_chk: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> (dac_code_o == SIGN_FLIP));

endmodule

// File: tb/tb_sar_conv_ctrl.sv
module tb_sar_conv_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // {diff, sample byte, expected result}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 8'h00},
        {1'b0, 8'hFF, 8'hFF},
        {1'b0, 8'h80, 8'h80},
        {1'b0, 8'h7F, 8'h7F},
        {1'b0, 8'h01, 8'h01},
        {1'b0, 8'hA5, 8'hA5},
        {1'b1, 8'h00, 8'h00},
        {1'b1, 8'hFF, 8'hFF},
        {1'b1, 8'h7F, 8'h7F},
        {1'b1, 8'h80, 8'h80},
        {1'b1, 8'h05, 8'h05},
        {1'b1, 8'h9C, 8'h9C}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic       diff_i;
    logic       cmp;
    logic [7:0] dac_user;
    logic [7:0] dac_code;
    logic       hold;
    logic       sample;
    logic [7:0] result;
    logic       done;

    logic [7:0] analog_level = 8'h00;
    logic [7:0] held_level = 8'h00;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_conv_ctrl dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .diff_i     (diff_i),
        .cmp_i      (cmp),
        .dac_user_i (dac_user),
        .dac_code_o (dac_code),
        .hold_o     (hold),
        .sample_o   (sample),
        .result_o   (result),
        .done_o     (done)
    );

    // comparator and input track-and-hold model
    always @(posedge clk) if (sample) held_level <= analog_level;
    assign cmp = (held_level >= dac_code);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_conv(input logic d, input logic [7:0] samp,
                            input logic [7:0] exp, input bit poke);
        logic [7:0] lvl;
        string rq;
        lvl = d ? (samp ^ 8'h80) : samp;
        rq  = d ? "R6" : "R5";
        analog_level = lvl;
        @(negedge clk);
        start_i = 1'b1;
        diff_i  = d;
        @(negedge clk);
        start_i = 1'b0;
        chk("R3 sample strobe", {7'd0, sample}, 8'd1);
        chk("R3 hold in sample", {7'd0, hold}, 8'd1);
        for (int k = 0; k < 8; k++) begin
            int m;
            int hm;
            if (poke && k == 2) begin
                start_i  = 1'b1;
                diff_i   = ~d;
                dac_user = 8'h11;
            end
            if (poke && k == 5) start_i = 1'b0;
            @(negedge clk);
            m  = 128 >> k;
            hm = 255 & ~(2*m - 1);
            chk("R4 trial code", dac_code, 8'((int'(lvl) & hm) | m));
            chk("R3 hold in trial", {7'd0, hold}, 8'd1);
            if (poke) chk("R8 no resample", {7'd0, sample}, 8'd0);
        end
        start_i = 1'b0;
        @(negedge clk);
        chk("R7 done pulse", {7'd0, done}, 8'd1);
        chk(poke ? "R9 result" : rq, result, exp);
        chk("R10 hold released", {7'd0, hold}, 8'd0);
        chk(poke ? "R11 dac back to new user" : "R10 dac back", dac_code, dac_user);
        @(negedge clk);
        chk("R7 done low", {7'd0, done}, 8'd0);
        chk("R7 result kept", result, exp);
        chk("R8 no restart", {7'd0, sample}, 8'd0);
        diff_i   = 1'b0;
        dac_user = 8'hC3;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        start_i  = 1'b0;
        diff_i   = 1'b0;
        dac_user = 8'h3C;
        repeat (3) @(negedge clk);
        chk("R1 result in reset", result, 8'h00);
        chk("R1 done in reset", {7'd0, done}, 8'd0);
        chk("R1 hold in reset", {7'd0, hold}, 8'd0);
        chk("R1 dac in reset", dac_code, 8'h3C);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 result after reset", result, 8'h00);
        chk("R1 sample after reset", {7'd0, sample}, 8'd0);
        dac_user = 8'hC3;
        #1;
        chk("R2 dac follows user", dac_code, 8'hC3);
        chk("R2 hold idle", {7'd0, hold}, 8'd0);

        for (int i = 0; i < NVEC; i++) begin
            run_conv(VEC[i][16], VEC[i][15:8], VEC[i][7:0], 1'b0);
        end

        // R8 R9 R11: start, diff flip and user change during conversion
        run_conv(1'b0, 8'h5A, 8'h5A, 1'b1);
        run_conv(1'b1, 8'hF6, 8'hF6, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule